// File: doc/BRIEF.md
# System Control Register Bank with Reset Key

This block is a 32-bit control and identification register bank behind a simple register bus. The bus has a byte address, a write enable, a read enable, write data and read data. Read data is combinational on the address. The bank decodes a 4 KB window and holds the following state:

- an identification word fixed by a parameter;
- an LED word and two configuration words;
- two flag words: one cleared by the block reset, one cleared only by a separate power-on reset. Each flag word has its own set address and its own clear address.
- a reset-level word.

Writes to the reset-level word are accepted only while a 16-bit lock register holds a key value. An accepted write with bit 8 set issues a one-cycle system reset request.

A small set of offsets returns fixed constants. A longer list of reserved offsets reads as zero and ignores writes. A read of any other offset returns zero and raises an error strobe for one cycle. The LED, configuration and reset-level words are driven straight out to the surrounding logic.

Top module: `sysctl_regbank`

## Requirements
- R1: When rst_ni is released, the LED, configuration, reset-level and lock words read 0, the volatile flag word reads 3, and no reset request or error strobe is active.
- R2: At offset 0x20, a write whose full 32-bit data equals 0x0000A05F stores 0xA05F and unlocks the bank. Any other write stores data[15:0] with bit 15 forced to 0, which leaves the bank locked. The register reads back zero-extended to 32 bits, and the bank is unlocked only while it holds 0xA05F.
- R3: A write to offset 0x40 updates the reset-level word only while the bank is unlocked. While locked, the write is dropped.
- R4: An accepted write to offset 0x40 with data bit 8 set drives sys_rst_req_o high for exactly the one cycle that follows the write's clock edge. Accepted writes without bit 8 set, and locked writes, give no request.
- R5: The volatile flag word reads at 0x30. A write to 0x30 ORs the data into it. A write to 0x34 clears the bits that are 1 in the data.
- R6: The non-volatile flag word reads at 0x38. A write to 0x38 sets bits and a write to 0x3C clears bits. It keeps its value through rst_ni and is cleared only by por_ni.
- R7: Offset 0x08 (LED) and offsets 0x28 and 0x2C (configuration A and B) are read/write words. Their values also appear on led_o, cfg_a_o and cfg_b_o.
- R8: Offset 0x00 reads the ID_VALUE parameter. Offset 0x44 reads 1, 0x50 reads 0x1000, 0x84 reads 0x02000000 and 0x88 reads 0xFF000000.
- R9: These reserved offsets read 0 with no error strobe: 0x04, 0x0C to 0x1C, 0x24, 0x48, 0x4C, 0x54 to 0x74, 0x80, 0x8C to 0x9C and 0xC0 to 0xD0 (word steps). Writes to any offset other than 0x08, 0x20, 0x28 to 0x40 change no state.
- R10: A read of any other address returns 0 and raises err_o for the one cycle after the read's clock edge. Other addresses include 0x34, 0x3C, any non-word-aligned address and anything at or above 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the non-volatile flags |
| addr_i | input | ADDR_W | Byte address inside the window |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable (qualifies the error strobe) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| err_o | output | 1 | One-cycle strobe after a read of an undefined address |
| led_o | output | 32 | LED word |
| cfg_a_o | output | 32 | Configuration word A |
| cfg_b_o | output | 32 | Configuration word B |
| rst_level_o | output | 32 | Reset-level word |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A corrupted lock register shows up in one of two ways: the reset-level word stops following accepted writes, or it starts following writes it should refuse. Either is visible on rst_level_o and sys_rst_req_o in the cycle after the write.

A faulty set/clear cell reveals itself at the next read of 0x30 or 0x38. Each read is compared against arithmetic on the data written so far.

A wrong decode entry shows up in the full read sweep of the window, as either a value or an err_o mismatch one cycle later. A dropped power-on domain shows as non-volatile flags that are lost across rst_ni.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [31:0] LOCK_KEY = 32'h0000_A05F;

  localparam logic [7:0] OFS_ID      = 8'h00;
  localparam logic [7:0] OFS_LED     = 8'h08;
  localparam logic [7:0] OFS_LOCK    = 8'h20;
  localparam logic [7:0] OFS_CFG_A   = 8'h28;
  localparam logic [7:0] OFS_CFG_B   = 8'h2C;
  localparam logic [7:0] OFS_FLG_SET = 8'h30;
  localparam logic [7:0] OFS_FLG_CLR = 8'h34;
  localparam logic [7:0] OFS_NV_SET  = 8'h38;
  localparam logic [7:0] OFS_NV_CLR  = 8'h3C;
  localparam logic [7:0] OFS_RST_LVL = 8'h40;

  typedef struct packed {
    logic led;
    logic lock;
    logic cfg_a;
    logic cfg_b;
    logic flg_set;
    logic flg_clr;
    logic nv_set;
    logic nv_clr;
    logic rst_lvl;
  } wr_strobe_t;

  typedef struct packed {
    logic        hit;
    logic [31:0] value;
  } fixed_rd_t;

  // constant and reserved read offsets; register offsets are muxed in the top
  function automatic fixed_rd_t fixed_read(input logic [7:0] ofs);
    fixed_rd_t r;
    r.hit   = 1'b1;
    r.value = 32'h0;
    case (ofs)
      8'h44: r.value = 32'h0000_0001;
      8'h50: r.value = 32'h0000_1000;
      8'h84: r.value = 32'h0200_0000;
      8'h88: r.value = 32'hFF00_0000;
      8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h24,
      8'h48, 8'h4C, 8'h54, 8'h58, 8'h5C, 8'h60,
      8'h64, 8'h68, 8'h6C, 8'h70, 8'h74, 8'h80,
      8'h8C, 8'h90, 8'h94, 8'h98, 8'h9C,
      8'hC0, 8'hC4, 8'hC8, 8'hCC, 8'hD0: r.value = 32'h0;
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sysctl_wdec.sv
module sysctl_wdec
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strobe_t        wstb_o
);

  localparam int HI_W = ADDR_W - 8;

  logic       in_page;
  logic [7:0] ofs;

  assign ofs     = addr_i[7:0];
  assign in_page = (addr_i[ADDR_W-1:8] == {HI_W{1'b0}}) && (ofs[1:0] == 2'b00);

  always_comb begin
    wstb_o = '0;
    if (we_i && in_page) begin
      case (ofs)
        OFS_LED:     wstb_o.led     = 1'b1;
        OFS_LOCK:    wstb_o.lock    = 1'b1;
        OFS_CFG_A:   wstb_o.cfg_a   = 1'b1;
        OFS_CFG_B:   wstb_o.cfg_b   = 1'b1;
        OFS_FLG_SET: wstb_o.flg_set = 1'b1;
        OFS_FLG_CLR: wstb_o.flg_clr = 1'b1;
        OFS_NV_SET:  wstb_o.nv_set  = 1'b1;
        OFS_NV_CLR:  wstb_o.nv_clr  = 1'b1;
        OFS_RST_LVL: wstb_o.rst_lvl = 1'b1;
        default:     wstb_o         = '0;
      endcase
    end
  end

  // R9: at most one register strobed per write
  always_comb begin
    a_r9_one_strobe: assert ($onehot0(wstb_o));
  end

endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [15:0] lock_o,
  output logic        unlocked_o
);

  logic [15:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 16'h0;
    end else if (we_i) begin
      if (wdata_i == LOCK_KEY) lock_q <= LOCK_KEY[15:0];
      else                     lock_q <= {1'b0, wdata_i[14:0]};
    end
  end

  assign lock_o     = lock_q;
  assign unlocked_o = (lock_q == LOCK_KEY[15:0]);

  a_r2_key_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == LOCK_KEY) |=> unlocked_o);
  a_r2_other_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i != LOCK_KEY) |=> (!unlocked_o && !lock_o[15]));

endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int          WIDTH   = 32,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= RST_VAL[WIDTH-1:0];
    else if (set_i) q <= q | data_i;
    else if (clr_i) q <= q & ~data_i;
  end

  assign q_o = q;

  a_r5_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(data_i)) == $past(data_i)));
  a_r5_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(data_i)) == '0));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h5A3C_0001,
  parameter int          ADDR_W   = 12,
  parameter int          FLAG_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic [31:0]       led_o,
  output logic [31:0]       cfg_a_o,
  output logic [31:0]       cfg_b_o,
  output logic [31:0]       rst_level_o,
  output logic              sys_rst_req_o
);

  localparam int HI_W      = ADDR_W - 8;
  localparam int RST_BIT   = 8;

  wr_strobe_t  wstb;
  logic [15:0] lock_val;
  logic        unlocked;
  logic [FLAG_W-1:0] flags, nv_flags;
  logic [31:0] led_q, cfg_a_q, cfg_b_q, lvl_q;
  logic        req_q, err_q;
  logic        in_page;
  logic [7:0]  ofs;
  fixed_rd_t   fx;
  logic        rd_known;
  logic [31:0] rd_val;

  sysctl_wdec #(.ADDR_W(ADDR_W)) i_wdec (
    .we_i   (we_i),
    .addr_i (addr_i),
    .wstb_o (wstb)
  );

  sysctl_lock i_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wstb.lock),
    .wdata_i    (wdata_i),
    .lock_o     (lock_val),
    .unlocked_o (unlocked)
  );

  sysctl_setclr #(.WIDTH(FLAG_W), .RST_VAL(32'h3)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wstb.flg_set),
    .clr_i  (wstb.flg_clr),
    .data_i (wdata_i[FLAG_W-1:0]),
    .q_o    (flags)
  );

  // non-volatile domain: power-on reset only
  sysctl_setclr #(.WIDTH(FLAG_W), .RST_VAL(32'h0)) i_nv_flags (
    .clk_i  (clk_i),
    .rst_ni (por_ni),
    .set_i  (wstb.nv_set),
    .clr_i  (wstb.nv_clr),
    .data_i (wdata_i[FLAG_W-1:0]),
    .q_o    (nv_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q   <= 32'h0;
      cfg_a_q <= 32'h0;
      cfg_b_q <= 32'h0;
      lvl_q   <= 32'h0;
      req_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wstb.led)   led_q   <= wdata_i;
      if (wstb.cfg_a) cfg_a_q <= wdata_i;
      if (wstb.cfg_b) cfg_b_q <= wdata_i;
      if (wstb.rst_lvl && unlocked) lvl_q <= wdata_i;
      req_q <= wstb.rst_lvl && unlocked && wdata_i[RST_BIT];
      err_q <= re_i && !rd_known;
    end
  end

  // read path
  assign ofs     = addr_i[7:0];
  assign in_page = (addr_i[ADDR_W-1:8] == {HI_W{1'b0}}) && (ofs[1:0] == 2'b00);
  assign fx      = fixed_read(ofs);

  always_comb begin
    rd_known = in_page;
    rd_val   = 32'h0;
    case (ofs)
      OFS_ID:      rd_val = ID_VALUE;
      OFS_LED:     rd_val = led_q;
      OFS_LOCK:    rd_val = {16'h0, lock_val};
      OFS_CFG_A:   rd_val = cfg_a_q;
      OFS_CFG_B:   rd_val = cfg_b_q;
      OFS_FLG_SET: rd_val = 32'(flags);
      OFS_NV_SET:  rd_val = 32'(nv_flags);
      OFS_RST_LVL: rd_val = lvl_q;
      default: begin
        rd_val   = fx.value;
        rd_known = in_page && fx.hit;
      end
    endcase
    if (!rd_known) rd_val = 32'h0;
  end

  assign rdata_o       = rd_val;
  assign err_o         = err_q;
  assign led_o         = led_q;
  assign cfg_a_o       = cfg_a_q;
  assign cfg_b_o       = cfg_b_q;
  assign rst_level_o   = lvl_q;
  assign sys_rst_req_o = req_q;

  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(rst_level_o));
  a_r4_req_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(we_i && unlocked && wdata_i[RST_BIT]));
  a_r10_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(re_i));
  a_r10_unknown_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_known |-> (rdata_o == 32'h0));

endmodule

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;

  localparam logic [31:0] ID = 32'h5A3C_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, led, cfga, cfgb, lvl;
  logic        err, req;

  int n_vec = 0, n_bad = 0;

  logic [31:0] m_led = 0, m_cfga = 0, m_cfgb = 0, m_lvl = 0, m_flg = 3, m_nv = 0;
  logic [15:0] m_lock = 0;

  always #5 clk = ~clk;

  sysctl_regbank #(.ID_VALUE(ID)) i_sysctl_regbank (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .addr_i(addr), .we_i(we),
    .re_i(re), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .led_o(led),
    .cfg_a_o(cfga), .cfg_b_o(cfgb), .rst_level_o(lvl), .sys_rst_req_o(req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit known(input int a);
    if (a >= 256 || (a % 4) != 0) return 0;
    if (a >= 'h0C && a <= 'h1C) return 1;
    if (a >= 'h54 && a <= 'h74) return 1;
    if (a >= 'h8C && a <= 'h9C) return 1;
    if (a >= 'hC0 && a <= 'hD0) return 1;
    case (a)
      'h00, 'h04, 'h08, 'h20, 'h24, 'h28, 'h2C, 'h30, 'h38, 'h40,
      'h44, 'h48, 'h4C, 'h50, 'h80, 'h84, 'h88: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_rd(input int a);
    if (!known(a)) return 0;
    case (a)
      'h00: return ID;
      'h08: return m_led;
      'h20: return {16'h0, m_lock};
      'h28: return m_cfga;
      'h2C: return m_cfgb;
      'h30: return m_flg;
      'h38: return m_nv;
      'h40: return m_lvl;
      'h44: return 32'h1;
      'h50: return 32'h1000;
      'h84: return 32'h0200_0000;
      'h88: return 32'hFF00_0000;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0; e = err;
  endtask

  task automatic rd_chk(input string tag, input int a);
    logic [31:0] d; logic e;
    rd(a[11:0], d, e);
    chk(tag, d, model_rd(a));
    chk({tag, "_err"}, {31'h0, e}, {31'h0, !known(a)});
  endtask

  task automatic lock_wr(input logic [31:0] d);
    wr(12'h020, d);
    m_lock = (d == 32'h0000_A05F) ? 16'hA05F : {1'b0, d[14:0]};
  endtask

  task automatic lvl_wr(input logic [31:0] d);
    logic acc;
    acc = (m_lock == 16'hA05F);
    wr(12'h040, d);
    if (acc) m_lvl = d;
    chk("R4_req", {31'h0, req}, {31'h0, acc && d[8]});
    chk("R3_lvl", lvl, m_lvl);
    @(negedge clk);
    chk("R4_drop", {31'h0, req}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1_led", led, 0); chk("R1_cfga", cfga, 0); chk("R1_cfgb", cfgb, 0);
    chk("R1_lvl", lvl, 0); chk("R1_req", {31'h0, req}, 0); chk("R1_err", {31'h0, err}, 0);
    rd_chk("R1_flags", 'h30); rd_chk("R1_lock", 'h20); rd_chk("R8_id", 'h00);

    // R7 plain words
    wr(12'h008, 32'hA5A5_0F0F); m_led = 32'hA5A5_0F0F;
    wr(12'h028, 32'h1234_5678); m_cfga = 32'h1234_5678;
    wr(12'h02C, 32'hDEAD_BEEF); m_cfgb = 32'hDEAD_BEEF;
    chk("R7_led_o", led, m_led); chk("R7_cfga_o", cfga, m_cfga); chk("R7_cfgb_o", cfgb, m_cfgb);
    rd_chk("R7_led", 'h08); rd_chk("R7_cfga", 'h28); rd_chk("R7_cfgb", 'h2C);

    // R3/R4 locked writes dropped
    lvl_wr(32'h0000_01FF);
    // R2 lock encodings
    foreach (lf[i]) begin end
    lock_wr(32'h0000_FFFF); rd_chk("R2_mask", 'h20); lvl_wr(32'h0000_0100);
    lock_wr(32'h1234_A05F); rd_chk("R2_upper", 'h20); lvl_wr(32'h0000_0100);
    lock_wr(32'h0000_205F); rd_chk("R2_near", 'h20); lvl_wr(32'h0000_0100);
    lock_wr(32'h0000_A05F); rd_chk("R2_key", 'h20);
    lvl_wr(32'h0000_0100);
    lvl_wr(32'h0000_00FF);
    lvl_wr(32'hFFFF_FFFF);
    rd_chk("R3_lvl_rd", 'h40);
    lock_wr(32'h0000_8000); rd_chk("R2_relock", 'h20);
    lvl_wr(32'h0000_0000);

    // R5/R6 set/clear sweep
    lf = 32'hACE1_1357;
    for (int i = 0; i < 48; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (i % 4)
        0: begin wr(12'h030, lf); m_flg = m_flg | lf; end
        1: begin wr(12'h034, lf); m_flg = m_flg & ~lf; end
        2: begin wr(12'h038, lf); m_nv = m_nv | lf; end
        default: begin wr(12'h03C, lf); m_nv = m_nv & ~lf; end
      endcase
      rd_chk("R5_flags", 'h30);
      rd_chk("R6_nv", 'h38);
    end

    // R9/R10 writes outside the writable set change nothing
    for (int a = 0; a < 256; a += 4) begin
      if (!(a == 'h08 || a == 'h20 || (a >= 'h28 && a <= 'h40)))
        wr(a[11:0], 32'hFFFF_FFFF);
    end
    wr(12'h100, 32'hFFFF_FFFF); wr(12'hFFC, 32'hFFFF_FFFF); wr(12'h00A, 32'hFFFF_FFFF);
    chk("R9_led_o", led, m_led); chk("R9_cfga_o", cfga, m_cfga);
    chk("R9_cfgb_o", cfgb, m_cfgb); chk("R9_lvl_o", lvl, m_lvl);

    // R8/R9/R10 full read sweep of the window
    for (int a = 0; a < 4096; a += 4) rd_chk("R10_sweep", a);
    rd_chk("R10_unaligned", 'h002);
    rd_chk("R10_unaligned", 'h031);

    // R6 survives block reset, cleared by power-on reset
    wr(12'h038, 32'h0000_00F0); m_nv = m_nv | 32'hF0;
    wr(12'h030, 32'h0000_0F00); m_flg = m_flg | 32'hF00;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_led = 0; m_cfga = 0; m_cfgb = 0; m_lvl = 0; m_flg = 3; m_lock = 0;
    rd_chk("R6_keep", 'h38); rd_chk("R1_flags2", 'h30); rd_chk("R1_lock2", 'h20);
    chk("R1_led2", led, 0);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    m_nv = 0;
    rd_chk("R6_por", 'h38);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule